// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block raises an interrupt request whenever the synchronized levels on a parallel port no longer match a snapshot of those levels. The snapshot is taken whenever a bus access touches the port, whether a read or a write. So the interrupt tells a host that some pin has moved since the host last looked at or drove the port. It is meant for a small remote I/O expander. Bus protocol handling and the pad drivers sit outside the block.

The request is level based. It falls again by itself if the pins go back to the snapshot value before any access happens. A read strobe or a write strobe reloads the snapshot from the current pins and forces the request off for that one clock.

The output is a pull-enable and not a logic level. A 1 means the shared interrupt wire must be pulled low, and a 0 means release it. Because of this, several such blocks can drive one wire with a pull-up. The output comes straight from a flop.

Top module: `port_change_irq`

## Requirements
- R1: While reset (active-low, sampled on the clock) is asserted, `irq_pull` is 0 and the snapshot is loaded from `pin_sync`. After reset, unchanged pins leave `irq_pull` at 0.
- R2: With no strobe, if `pin_sync` differs from the snapshot in at least one bit, `irq_pull` is 1 after the next rising clock edge. This holds for a bit going 0 to 1 and for a bit going 1 to 0, and the request stays 1 while the difference lasts.
- R3: With no strobe, if `pin_sync` equals the snapshot again, `irq_pull` is 0 after the next rising clock edge.
- R4: A clock with `rd_stb` high loads the snapshot from `pin_sync` in that clock, and `irq_pull` is 0 after that edge.
- R5: A clock with `wr_stb` high has the same effect as a read strobe: the snapshot is reloaded and `irq_pull` is 0 after that edge.
- R6: Masking covers only the strobe clock. A pin change present in the strobe clock is absorbed into the snapshot and raises nothing. A difference seen in any later clock raises `irq_pull` one clock later.
- R7: `irq_pull` is a flop output. A pin change partway through a clock period does not move it before the next rising edge.
- R8: `rd_stb` and `wr_stb` high in the same clock act as a single access. A difference in several bits at once raises one request, exactly as a single-bit difference does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_sync | input | WIDTH | Port pin levels, already synchronized to clk |
| rd_stb | input | 1 | One-clock pulse for a port read access |
| wr_stb | input | 1 | One-clock pulse for a port write access |
| irq_pull | output | 1 | 1 = pull the shared interrupt wire low |

## Verification
The assertions assume that `pin_sync` is already synchronous to `clk`, so its value at each rising edge is the value the block compares. They also assume the strobes are clean one-clock pulses. The stimulus meets both assumptions by changing pins and strobes only on falling edges. Outputs are sampled one falling edge later. The only deliberate exception is the mid-period pin change that tests R7, which the bench still makes between edges.

// File: rtl/pcig_pkg.sv
package pcig_pkg;

  // Any bit of the current port value differs from the stored snapshot.
  function automatic logic port_moved(input logic [63:0] now_v,
                                      input logic [63:0] snap_v);
    return |(now_v ^ snap_v);
  endfunction

  // A bus access of either kind is in progress.
  function automatic logic bus_touch(input logic rd, input logic wr);
    return rd | wr;
  endfunction

endpackage

// File: rtl/pcig_units.sv
module pcig_snapshot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] snap
);
  // Reset and an access both seed the snapshot from the live pins.
  always_ff @(posedge clk) begin
    if (!rst_n || reload) snap <= pins;
  end
endmodule

module pcig_compare #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] pins,
  input  logic [WIDTH-1:0] snap,
  output logic             moved
);
  import pcig_pkg::*;
  localparam int PAD = 64 - WIDTH;

  generate
    if (PAD > 0) begin : g_pad
      always_comb moved = port_moved({{PAD{1'b0}}, pins}, {{PAD{1'b0}}, snap});
    end else begin : g_full
      always_comb moved = port_moved(pins[63:0], snap[63:0]);
    end
  endgenerate
endmodule

module pcig_irq_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic mask,
  input  logic moved,
  output logic pull
);
  // Masked in the reload clock; otherwise follows the comparison.
  always_ff @(posedge clk) begin
    if (!rst_n)    pull <= 1'b0;
    else if (mask) pull <= 1'b0;
    else           pull <= moved;
  end
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic             rd_stb,
  input  logic             wr_stb,
  output logic             irq_pull
);
  import pcig_pkg::*;

  logic             access;
  logic             mismatch;
  logic [WIDTH-1:0] snap_q;

  always_comb access = bus_touch(rd_stb, wr_stb);

  pcig_snapshot #(.WIDTH(WIDTH)) u_snap (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (access),
    .pins   (pin_sync),
    .snap   (snap_q)
  );

  pcig_compare #(.WIDTH(WIDTH)) u_cmp (
    .pins  (pin_sync),
    .snap  (snap_q),
    .moved (mismatch)
  );

  pcig_irq_reg u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .mask  (access),
    .moved (mismatch),
    .pull  (irq_pull)
  );
endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] pin_sync,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic             irq_pull,
  input logic [WIDTH-1:0] snap_q,
  input logic             mismatch
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !irq_pull);

  // R2
  raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb && (pin_sync != snap_q)) |=> irq_pull);

  // R3
  fall_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb && (pin_sync == snap_q)) |=> !irq_pull);

  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (!irq_pull && snap_q == $past(pin_sync)));

  // R5
  write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (!irq_pull && snap_q == $past(pin_sync)));

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb) |=> $stable(snap_q));

  // R8
  moved_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch == (pin_sync != snap_q));
endmodule

bind port_change_irq port_change_irq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_sync (pin_sync),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .irq_pull (irq_pull),
  .snap_q   (snap_q),
  .mismatch (mismatch)
);

// File: tb/port_change_irq_bench.sv
`timescale 1ns/1ps
module port_change_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_sync = 8'hA5;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic       irq_pull;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  port_change_irq #(.WIDTH(8)) u_port_change_irq (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .irq_pull(irq_pull)
  );

  // {requirement, pins, {rd, wr, expected irq, 0}}, snapshot starts at A5
  localparam logic [15:0] VEC [0:17] = '{
    16'h1A50,  // R1 quiet after reset
    16'h2A42,  // R2 bit0 falls
    16'h3A50,  // R3 back to snapshot
    16'h2E52,  // R2 bit6 rises
    16'h4E58,  // R4 read clears
    16'h4E50,  // R4 snapshot now E5
    16'h2652,  // R2 bit7 falls
    16'h5654,  // R5 write clears
    16'h5650,  // R5 snapshot now 65
    16'h6008,  // R6 change inside strobe clock absorbed
    16'h6000,  // R6 still quiet
    16'h6012,  // R6 next change raises
    16'h2012,  // R2 held while different
    16'h8FFC,  // R8 both strobes, multi-bit change
    16'h6FE2,  // R6 change right after strobe
    16'h4FE8,  // R4 read clears again
    16'h2FF2,  // R2 bit0 rises
    16'h3FE0   // R3 return clears
  };

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s irq_pull=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(irq_pull, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    for (int i = 0; i < 18; i++) begin
      pin_sync = VEC[i][11:4];
      rd_stb   = VEC[i][3];
      wr_stb   = VEC[i][2];
      @(negedge clk);
      check(irq_pull, VEC[i][1], $sformatf("R%0d vector %0d", VEC[i][15:12], i));
    end
    rd_stb = 1'b0;
    wr_stb = 1'b0;
    // R7: a mid-period change must not reach the output before the edge
    #2 pin_sync = 8'h0F;
    #2 check(irq_pull, 1'b0, "R7 before edge");
    @(negedge clk);
    check(irq_pull, 1'b1, "R7 after edge");
    // R1: reset drops a live request and seeds the snapshot
    rst_n = 1'b0;
    @(negedge clk);
    check(irq_pull, 1'b0, "R1 reset drops request");
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_pull, 1'b0, "R1 seeded snapshot");
    pin_sync = 8'h0E;
    @(negedge clk);
    check(irq_pull, 1'b1, "R2 after reseed");
    pin_sync = 8'h0F;
    @(negedge clk);
    check(irq_pull, 1'b0, "R3 after reseed");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired irq_pull=%b expected=finish", irq_pull);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule